// File: doc/BRIEF.md
# 8-bit ALU with Condition Flags

A purely combinational arithmetic, logic and shift unit for an 8-bit accumulator datapath. Each cycle it takes two operands, the current carry and half-carry bits and a 4-bit operation code. It returns an 8-bit result, a fresh set of negative, zero, overflow, half-carry and carry flags, and a write-enable. The write-enable tells the surrounding datapath whether the result is meant to be stored.

Operand fetch, flag storage and register writeback belong to the caller. Flags that an operation does not define are passed through from the `c_i` and `h_i` inputs, so the caller can always load all five flag outputs into its condition register. Single-operand operations (shifts, rotates, increment) work on `a_i`. The load operation passes `b_i`.

Top module: `alu8_core`

## Requirements
- R1: ADD (op 0) and ADC (op 1) form a 9-bit sum of `a_i`, `b_i` and, for ADC only, `c_i`. `res_o` is its low 8 bits, `c_o` is its bit 8, and `h_o` is bit 4 of `a_i ^ b_i ^ sum`.
- R2: SUB (op 2) and SBC (op 3) form a 9-bit difference `a_i - b_i`, minus `c_i` for SBC only. `c_o` is bit 8 of that difference, which is 1 on a borrow. `h_o` equals `h_i`.
- R3: For ops 0 to 4, `v_o` is bit 7 of `a ^ b ^ r ^ (r >> 1)`, where `a` and `b` are zero-extended to 9 bits and `r` is the raw 9-bit result.
- R4: CMP (op 4) produces the same flags as SUB and drives `we_o` low. Every op other than CMP and BIT drives `we_o` high.
- R5: AND (op 5), OR (op 6), XOR (op 7) and LOAD (op 9, result = `b_i`) clear `v_o` and pass `c_i` and `h_i` to `c_o` and `h_o`.
- R6: BIT (op 8) sets its flags from `a_i & b_i` in the same way as AND and drives `we_o` low.
- R7: ASR (op 10) keeps bit 7 of `a_i`, and LSR (op 11) clears it. Both shift right by one and move the old bit 0 into `c_o`.
- R8: LSL (op 12) shifts left and fills bit 0 with 0. ROL (op 13) fills bit 0 with `c_i`. Both move the old bit 7 into `c_o`. ROR (op 14) shifts right, fills bit 7 with `c_i` and moves the old bit 0 into `c_o`.
- R9: For ops 10 to 14, `v_o` equals `c_o ^ n_o` and `h_o` equals `h_i`.
- R10: INC (op 15) returns `a_i + 1` modulo 256. It sets `v_o` exactly when the result is 0x80 and passes `c_i` and `h_i` through.
- R11: For every op, `n_o` is bit 7 of `res_o`, and `z_o` is 1 exactly when `res_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (0 to 15) |
| a_i | input | 8 | First operand; the source for shifts and increment |
| b_i | input | 8 | Second operand; the source for load |
| c_i | input | 1 | Incoming carry flag |
| h_i | input | 1 | Incoming half-carry flag |
| res_o | output | 8 | Result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| h_o | output | 1 | Half-carry flag |
| c_o | output | 1 | Carry flag |
| we_o | output | 1 | High when the result should be written back |

## Verification
Write-back suppression and flag generation occur together on compare and bit-test. A stuck or inverted write-enable can therefore hide behind correct flags. Vectors for both ops are chosen so that the flags are non-trivial: a zero result, a signed overflow on compare, and a negative AND result on bit-test. Each vector is judged on the result, all five flags and `we_o` at once. A second pairing, carry-in consumed versus carry passed through, is provoked by driving `c_i` high on ADD, SUB, the logic ops and increment. Each outcome is then compared against the carry that the requirement expects.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_BIT  = 4'd8,
    OP_LOAD = 4'd9,
    OP_ASR  = 4'd10,
    OP_LSR  = 4'd11,
    OP_LSL  = 4'd12,
    OP_ROL  = 4'd13,
    OP_ROR  = 4'd14,
    OP_INC  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_OR   = 2'd1,
    LG_XOR  = 2'd2,
    LG_PASS = 2'd3
  } logic_fn_e;

  typedef enum logic [2:0] {
    SH_ASR = 3'd0,
    SH_LSR = 3'd1,
    SH_LSL = 3'd2,
    SH_ROL = 3'd3,
    SH_ROR = 3'd4
  } shift_fn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic h;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         use_cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o,
  output logic         h_o
);
  localparam int unsigned HBIT = W / 2;

  logic [W:0] opa, opb, cext, raw, mix, vmix;

  always_comb begin
    opa  = {1'b0, a_i};
    opb  = {1'b0, b_i};
    cext = {{W{1'b0}}, cin_i & use_cin_i};
    if (sub_i) raw = opa - opb - cext;
    else       raw = opa + opb + cext;
    mix   = opa ^ opb ^ raw;
    vmix  = mix ^ (raw >> 1);
    sum_o = raw[W-1:0];
    c_o   = raw[W];      // carry out or borrow
    v_o   = vmix[W-1];
    h_o   = mix[HBIT];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic_fn_e    fn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (fn_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = b_i;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  shift_fn_e    fn_i,
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  always_comb begin
    res_o = a_i;
    c_o   = cin_i;
    unique case (fn_i)
      SH_ASR: begin res_o = {a_i[W-1], a_i[W-1:1]}; c_o = a_i[0];   end
      SH_LSR: begin res_o = {1'b0, a_i[W-1:1]};     c_o = a_i[0];   end
      SH_LSL: begin res_o = {a_i[W-2:0], 1'b0};     c_o = a_i[W-1]; end
      SH_ROL: begin res_o = {a_i[W-2:0], cin_i};    c_o = a_i[W-1]; end
      SH_ROR: begin res_o = {cin_i, a_i[W-1:1]};    c_o = a_i[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  input  logic         h_i,
  output logic [W-1:0] res_o,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o,
  output logic         h_o,
  output logic         c_o,
  output logic         we_o
);
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] SGN_MIN = {1'b1, {(W-1){1'b0}}};

  alu_op_e    op;
  logic       is_sub, use_cin;
  logic [W-1:0] as_sum, lg_res, sh_res, inc_res;
  logic       as_c, as_v, as_h, sh_c;
  logic_fn_e  lg_fn;
  shift_fn_e  sh_fn;
  alu_flags_t fl;

  assign op      = alu_op_e'(op_i);
  assign is_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign use_cin = (op == OP_ADC) || (op == OP_SBC);

  always_comb begin
    unique case (op)
      OP_OR:   lg_fn = LG_OR;
      OP_XOR:  lg_fn = LG_XOR;
      OP_LOAD: lg_fn = LG_PASS;
      default: lg_fn = LG_AND;
    endcase
    unique case (op)
      OP_LSR:  sh_fn = SH_LSR;
      OP_LSL:  sh_fn = SH_LSL;
      OP_ROL:  sh_fn = SH_ROL;
      OP_ROR:  sh_fn = SH_ROR;
      default: sh_fn = SH_ASR;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a_i      (a_i),
    .b_i      (b_i),
    .cin_i    (c_i),
    .use_cin_i(use_cin),
    .sub_i    (is_sub),
    .sum_o    (as_sum),
    .c_o      (as_c),
    .v_o      (as_v),
    .h_o      (as_h)
  );

  alu8_logic #(.W(W)) u_logic (
    .fn_i (lg_fn),
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(lg_res)
  );

  alu8_shift #(.W(W)) u_shift (
    .fn_i (sh_fn),
    .a_i  (a_i),
    .cin_i(c_i),
    .res_o(sh_res),
    .c_o  (sh_c)
  );

  assign inc_res = a_i + ONE;

  always_comb begin
    res_o = lg_res;
    fl    = '{n: 1'b0, z: 1'b0, v: 1'b0, h: h_i, c: c_i};
    we_o  = 1'b1;
    unique case (op)
      OP_ADD, OP_ADC: begin
        res_o = as_sum; fl.c = as_c; fl.v = as_v; fl.h = as_h;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        res_o = as_sum; fl.c = as_c; fl.v = as_v;
        we_o  = (op != OP_CMP);
      end
      OP_AND, OP_OR, OP_XOR, OP_LOAD, OP_BIT: begin
        res_o = lg_res;
        we_o  = (op != OP_BIT);
      end
      OP_ASR, OP_LSR, OP_LSL, OP_ROL, OP_ROR: begin
        res_o = sh_res; fl.c = sh_c;
      end
      default: begin
        res_o = inc_res;
        fl.v  = (inc_res == SGN_MIN);
      end
    endcase
    fl.n = res_o[W-1];
    fl.z = ~|res_o;
    if (op inside {OP_ASR, OP_LSR, OP_LSL, OP_ROL, OP_ROR}) fl.v = fl.c ^ fl.n;
  end

  assign n_o = fl.n;
  assign z_o = fl.z;
  assign v_o = fl.v;
  assign h_o = fl.h;
  assign c_o = fl.c;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         c_i,
  input logic         h_i,
  input logic [W-1:0] res_o,
  input logic         n_o,
  input logic         z_o,
  input logic         v_o,
  input logic         h_o,
  input logic         c_o,
  input logic         we_o
);
  alu_op_e    op;
  logic [W:0] exp_sum;
  logic       is_shift, is_lgc, is_add;

  always_comb begin
    op       = alu_op_e'(op_i);
    is_add   = (op == OP_ADD) || (op == OP_ADC);
    is_shift = op inside {OP_ASR, OP_LSR, OP_LSL, OP_ROL, OP_ROR};
    is_lgc   = op inside {OP_AND, OP_OR, OP_XOR, OP_LOAD, OP_BIT};
    exp_sum  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, (op == OP_ADC) & c_i};

    p_carry_sum_r1: assert (!is_add || ({c_o, res_o} == exp_sum))
      else $error("sum/carry mismatch");
    p_h_hold_r2: assert (is_add || (h_o == h_i))
      else $error("half carry changed outside add");
    p_no_write_r4: assert (we_o == !(op == OP_CMP || op == OP_BIT))
      else $error("write enable wrong");
    p_logic_v_r5: assert (!is_lgc || (!v_o && c_o == c_i))
      else $error("logic op touched V or C");
    p_shift_v_r9: assert (!is_shift || (v_o == (c_o ^ n_o)))
      else $error("shift overflow not C^N");
    p_inc_flags_r10: assert (op != OP_INC ||
                             (c_o == c_i && v_o == (res_o == {1'b1, {(W-1){1'b0}}})))
      else $error("increment flags wrong");
    p_nz_r11: assert (n_o == res_o[W-1] && z_o == (res_o == '0))
      else $error("N/Z mismatch");
  end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (.*);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] a_i = 8'h00, b_i = 8'h00, res_o;
  logic       c_i = 1'b0, h_i = 1'b0;
  logic       n_o, z_o, v_o, h_o, c_o, we_o;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  alu8_core dut_i (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i), .h_i(h_i),
    .res_o(res_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .h_o(h_o),
    .c_o(c_o), .we_o(we_o)
  );

  // {op, a, b, c_in, h_in, res, flags NZVHC, we}
  localparam int NV = 24;
  localparam logic [35:0] VEC [NV] = '{
    {4'd0,  8'h3A, 8'h46, 1'b1, 1'b0, 8'h80, 5'b10110, 1'b1},
    {4'd1,  8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 5'b01011, 1'b1},
    {4'd1,  8'h12, 8'h34, 1'b0, 1'b1, 8'h46, 5'b00000, 1'b1},
    {4'd2,  8'h80, 8'h01, 1'b1, 1'b1, 8'h7F, 5'b00110, 1'b1},
    {4'd2,  8'h10, 8'h20, 1'b0, 1'b0, 8'hF0, 5'b10001, 1'b1},
    {4'd3,  8'h50, 8'h4F, 1'b1, 1'b0, 8'h00, 5'b01000, 1'b1},
    {4'd3,  8'h00, 8'h00, 1'b1, 1'b1, 8'hFF, 5'b10011, 1'b1},
    {4'd4,  8'h05, 8'h05, 1'b1, 1'b0, 8'h00, 5'b01000, 1'b0},
    {4'd4,  8'h7F, 8'hFF, 1'b0, 1'b0, 8'h80, 5'b10101, 1'b0},
    {4'd5,  8'hF0, 8'h0F, 1'b1, 1'b1, 8'h00, 5'b01011, 1'b1},
    {4'd6,  8'h81, 8'h02, 1'b0, 1'b0, 8'h83, 5'b10000, 1'b1},
    {4'd7,  8'hAA, 8'hAA, 1'b1, 1'b0, 8'h00, 5'b01001, 1'b1},
    {4'd8,  8'hC3, 8'h81, 1'b0, 1'b1, 8'h81, 5'b10010, 1'b0},
    {4'd9,  8'h12, 8'h00, 1'b0, 1'b0, 8'h00, 5'b01000, 1'b1},
    {4'd10, 8'h81, 8'h5A, 1'b0, 1'b0, 8'hC0, 5'b10001, 1'b1},
    {4'd11, 8'h81, 8'h5A, 1'b0, 1'b1, 8'h40, 5'b00111, 1'b1},
    {4'd11, 8'h01, 8'h5A, 1'b0, 1'b0, 8'h00, 5'b01101, 1'b1},
    {4'd12, 8'h40, 8'h5A, 1'b1, 1'b0, 8'h80, 5'b10100, 1'b1},
    {4'd13, 8'h80, 8'h5A, 1'b1, 1'b0, 8'h01, 5'b00101, 1'b1},
    {4'd14, 8'h01, 8'h5A, 1'b1, 1'b0, 8'h80, 5'b10001, 1'b1},
    {4'd14, 8'h00, 8'h5A, 1'b0, 1'b0, 8'h00, 5'b01000, 1'b1},
    {4'd15, 8'h7F, 8'h5A, 1'b1, 1'b0, 8'h80, 5'b10101, 1'b1},
    {4'd15, 8'hFF, 8'h5A, 1'b0, 1'b1, 8'h00, 5'b01010, 1'b1},
    {4'd15, 8'h80, 8'h5A, 1'b0, 1'b0, 8'h81, 5'b10000, 1'b1}
  };

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0, 4'd1:          return "R1/R3";
      4'd2, 4'd3:          return "R2/R3";
      4'd4:                return "R4/R3";
      4'd5, 4'd6, 4'd7, 4'd9: return "R5";
      4'd8:                return "R6";
      4'd10, 4'd11:        return "R7/R9";
      4'd15:               return "R10";
      default:             return "R8/R9";
    endcase
  endfunction

  task automatic check(string req, logic [14:0] act, logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got res=%h NZVHC=%b we=%b, exp res=%h NZVHC=%b we=%b",
               req, act[13:6], act[5:1], act[0], exp[13:6], exp[5:1], exp[0]);
    end
  endtask

  task automatic apply(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic c, logic h);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; c_i = c; h_i = h;
    #5;
  endtask

  function automatic logic [14:0] observed();
    return {1'b0, res_o, n_o, z_o, v_o, h_o, c_o, we_o};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle state: ADD of zeros
    apply(4'd0, 8'h00, 8'h00, 1'b0, 1'b0);
    check("R11 idle", observed(), {1'b0, 8'h00, 5'b01000, 1'b1});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][35:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15], VEC[i][14]);
      check(req_of(VEC[i][35:32]), observed(), {1'b0, VEC[i][13:0]});
    end

    // R10: overflow exactly at 0x7F -> 0x80 across the whole operand range
    for (int a = 0; a < 256; a++) begin
      apply(4'd15, 8'(a), 8'h00, a[0], a[1]);
      check("R10 sweep", {1'b0, res_o, v_o, c_o, h_o, 3'b000},
            {1'b0, 8'(a + 1), (a == 127), a[0], a[1], 3'b000});
    end

    // R1: ADD ignores carry-in while ADC consumes it
    apply(4'd0, 8'h0F, 8'h00, 1'b1, 1'b0);
    check("R1 add no cin", observed(), {1'b0, 8'h0F, 5'b00000, 1'b1});
    apply(4'd1, 8'h0F, 8'h00, 1'b1, 1'b0);
    check("R1 adc half", observed(), {1'b0, 8'h10, 5'b00010, 1'b1});

    // R2: SUB ignores carry-in, borrow from zero
    apply(4'd2, 8'h00, 8'h01, 1'b1, 1'b0);
    check("R2 borrow", observed(), {1'b0, 8'hFF, 5'b10001, 1'b1});

    // R11: N and Z with XOR producing 0x80
    apply(4'd7, 8'h7F, 8'hFF, 1'b0, 1'b0);
    check("R11 xor neg", observed(), {1'b0, 8'h80, 5'b10000, 1'b1});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 20000; cyc++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung, exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule